// File: doc/BRIEF.md
# Banked Memory Address Translator

This block is the purely combinational front end of a banked memory manager for an 8-bit system with a 16-bit address bus and two 64 KB RAM banks. It receives the bus address, a flag telling whether the processor or the video engine owns the bus, and the current contents of the configuration, mode, RAM-sharing and page-pointer registers. Register storage lives outside. From these inputs it produces a translated address, four memory-select strobes and two bank column strobes. Only the upper byte of the address is ever rewritten. The low byte passes straight through.

Every access is first sorted into one region, and that region decides the outputs. The regions are: VIDEO (video engine owns the bus), COMPAT (compatibility mode), MMUREG (the register window at 0xFF00..0xFF04), ALTROM (the low-memory overlay used while the alternate processor runs), PAGE0 and PAGE1 (relocated zero page and stack page), LOROM, MIDROM and HIROM (the three ROM windows), and PLAIN (ordinary RAM at 0x0200..0x3FFF). The block has no clock, so no region is held from one access to the next. The region is a decode of the present inputs and moves to a new value at once whenever the address, the bus owner or a register changes. After the region is chosen, a shared-RAM window can override the bank choice, and a page that a pointer maps elsewhere is swapped back into page 0 or page 1.

Top module: `mmu_xlat_top`

## Requirements
- R1: mem_sel[2] always equals cfg_reg[0] (I/O select). mem_sel[3] always equals the inverse of compat. mem_sel[1:0] is 2'b11 (RAM) unless R5 or R7 says otherwise.
- R2: When cpu_owns=0, xlat_addr[15:8] = 0xF0 | bus_addr[11:8]. bank_strobe[0] = vid_bank and bank_strobe[1] = ~vid_bank.
- R3: When cpu_owns=1, xlat_addr[15:8] passes through by default. bank_strobe[0] = cfg_reg[6] (bank bit) and bank_strobe[1] is its inverse. With compat=1 no other rule applies.
- R4: A processor access to 0xFF00..0xFF04 with compat=0 drives bank_strobe to 2'b11 and leaves the page unchanged.
- R5: With compat=0, cpu_sel=0 and cfg_reg[6]=0, addresses below 0x1000 map to page 0xD0 | bus_addr[11:8] with mem_sel[1:0]=2'b00. The shared-RAM override does not apply to these accesses.
- R6: With compat=0, page 0x00 maps to page pg0_lo and bank_strobe[0] = pg0_bank. Page 0x01 maps to pg1_lo and bank_strobe[0] = pg1_bank.
- R7: ROM windows set mem_sel[1:0] = {ms1, ms0}. For 0x4000..0x7FFF both bits equal cfg_reg[1]. For 0x8000..0xBFFF, ms0=cfg_reg[2] and ms1=cfg_reg[3]. For 0xC000..0xFFFF (outside R4), ms0=cfg_reg[4] and ms1=cfg_reg[5].
- R8: In regions PAGE0, PAGE1, ROM and PLAIN, when mem_sel[1:0]=2'b11, the translated page becomes 0x00 if the original page equals pg0_lo, or else 0x01 if it equals pg1_lo.
- R9: share_size 0,1,2,3 selects a span of 1K, 4K, 8K or 16K. In the same regions as R8, an address below the span (with share_bottom=1), or at or above 0x10000 minus the span (with share_top=1), forces bank_strobe=2'b10 (cas0=0, cas1=1).
- R10: xlat_addr[7:0] always equals bus_addr[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_addr | input | 16 | Bus address |
| cpu_owns | input | 1 | 1: processor access, 0: video access |
| compat | input | 1 | Compatibility mode |
| cpu_sel | input | 1 | 1: main processor, 0: alternate processor |
| cfg_reg | input | 7 | bit0 I/O, bit1 low ROM, 3:2 mid ROM, 5:4 high ROM, bit6 bank |
| share_size | input | 2 | Shared-RAM span code |
| share_bottom | input | 1 | Bottom shared window enable |
| share_top | input | 1 | Top shared window enable |
| vid_bank | input | 1 | Bank used by the video engine |
| pg0_lo | input | 8 | Page-0 target page |
| pg0_bank | input | 1 | Page-0 target bank |
| pg1_lo | input | 8 | Page-1 target page |
| pg1_bank | input | 1 | Page-1 target bank |
| xlat_addr | output | 16 | Translated address |
| mem_sel | output | 4 | Memory-select strobes ms3..ms0 |
| bank_strobe | output | 2 | Bank column strobes {cas1, cas0} |

## Verification
Two rules can apply to the same access: page relocation or swapping (R6, R8) and the shared-RAM override (R9). One case is a zero-page access with bottom sharing enabled, where pg0_bank would select bank 1 but the override forces bank 0. Another is a top-share access inside a RAM-selected ROM window whose page equals a pointer. The bench provokes both by aiming pointers at the current page and by sweeping every share size with both enables set. It judges each access against a behavioural model that applies the page rewrite and the bank override independently.

// File: rtl/mmu_xlat_pkg.sv
package mmu_xlat_pkg;

    typedef enum logic [3:0] {
        RG_VIDEO,
        RG_COMPAT,
        RG_MMUREG,
        RG_ALTROM,
        RG_PAGE0,
        RG_PAGE1,
        RG_LOROM,
        RG_MIDROM,
        RG_HIROM,
        RG_PLAIN
    } region_e;

    localparam logic [7:0] REG_PAGE     = 8'hFF;
    localparam logic [7:0] REG_LAST_LOW = 8'h04;
    localparam logic [3:0] VID_NIBBLE   = 4'hF;
    localparam logic [3:0] ALT_NIBBLE   = 4'hD;

    // span of the shared window: 1K for code 0, then 4K, 8K, 16K
    function automatic logic [16:0] share_span(input logic [1:0] code);
        if (code == 2'd0)
            return 17'h00400;
        else
            return 17'h00800 << code;
    endfunction

    // regions in which pointer swap and shared-RAM override take effect
    function automatic logic ram_rules_apply(input region_e rg);
        return (rg == RG_PAGE0) || (rg == RG_PAGE1) || (rg == RG_LOROM) ||
               (rg == RG_MIDROM) || (rg == RG_HIROM) || (rg == RG_PLAIN);
    endfunction

endpackage

// File: rtl/mmu_region_classify.sv
module mmu_region_classify
    import mmu_xlat_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_owns,
    input  logic              compat,
    input  logic              overlay_en,
    output region_e           region
);
    localparam int PAGE_W = 8;
    localparam int LOW_W  = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] page;
    logic [LOW_W-1:0]  low;

    assign page = addr[ADDR_W-1 -: PAGE_W];
    assign low  = addr[LOW_W-1:0];

    always_comb begin
        if (!cpu_owns)
            region = RG_VIDEO;
        else if (compat)
            region = RG_COMPAT;
        else if (page == REG_PAGE && low <= REG_LAST_LOW)
            region = RG_MMUREG;
        else if (overlay_en && addr[ADDR_W-1 -: 4] == 4'h0)
            region = RG_ALTROM;
        else if (page == 8'h00)
            region = RG_PAGE0;
        else if (page == 8'h01)
            region = RG_PAGE1;
        else begin
            unique case (addr[ADDR_W-1 -: 2])
                2'b01:   region = RG_LOROM;
                2'b10:   region = RG_MIDROM;
                2'b11:   region = RG_HIROM;
                default: region = RG_PLAIN;
            endcase
        end
    end

endmodule

// File: rtl/mmu_rom_select.sv
module mmu_rom_select
    import mmu_xlat_pkg::*;
(
    input  region_e     region,
    input  logic        rom_lo,
    input  logic [1:0]  rom_mid,
    input  logic [1:0]  rom_hi,
    output logic [1:0]  sel
);
    // sel[0] is ms0, sel[1] is ms1
    always_comb begin
        unique case (region)
            RG_ALTROM: sel = 2'b00;
            RG_LOROM:  sel = {rom_lo, rom_lo};
            RG_MIDROM: sel = rom_mid;
            RG_HIROM:  sel = rom_hi;
            default:   sel = 2'b11;
        endcase
    end

endmodule

// File: rtl/mmu_page_map.sv
module mmu_page_map
    import mmu_xlat_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  region_e           region,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              ram_sel,
    input  logic [PAGE_W-1:0] pg0_lo,
    input  logic [PAGE_W-1:0] pg1_lo,
    output logic [PAGE_W-1:0] page_out
);
    localparam logic [PAGE_W-1:0] PAGE_ZERO = '0;
    localparam logic [PAGE_W-1:0] PAGE_ONE  = PAGE_W'(1);

    logic [PAGE_W-1:0] base_page;
    logic              hit0;
    logic              hit1;
    logic              swap_ok;

    always_comb begin
        unique case (region)
            RG_VIDEO:  base_page = {VID_NIBBLE, page_in[3:0]};
            RG_ALTROM: base_page = {ALT_NIBBLE, page_in[3:0]};
            RG_PAGE0:  base_page = pg0_lo;
            RG_PAGE1:  base_page = pg1_lo;
            default:   base_page = page_in;
        endcase
    end

    assign hit0    = (page_in == pg0_lo);
    assign hit1    = (page_in == pg1_lo);
    assign swap_ok = ram_rules_apply(region) && ram_sel;

    always_comb begin
        if (swap_ok && hit0)
            page_out = PAGE_ZERO;
        else if (swap_ok && hit1)
            page_out = PAGE_ONE;
        else
            page_out = base_page;
    end

endmodule

// File: rtl/mmu_share_window.sv
module mmu_share_window
    import mmu_xlat_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size_code,
    input  logic              bottom_en,
    input  logic              top_en,
    output logic              hit
);
    localparam logic [ADDR_W:0] SPACE = (ADDR_W+1)'(1) << ADDR_W;

    logic [ADDR_W:0] span;
    logic [ADDR_W:0] wide_addr;

    assign span      = (ADDR_W+1)'(share_span(size_code));
    assign wide_addr = {1'b0, addr};
    assign hit       = (bottom_en && wide_addr < span) ||
                       (top_en && wide_addr >= SPACE - span);

endmodule

// File: rtl/mmu_xlat_top.sv
module mmu_xlat_top
    import mmu_xlat_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              cpu_owns,
    input  logic              compat,
    input  logic              cpu_sel,
    input  logic [6:0]        cfg_reg,
    input  logic [1:0]        share_size,
    input  logic              share_bottom,
    input  logic              share_top,
    input  logic              vid_bank,
    input  logic [7:0]        pg0_lo,
    input  logic              pg0_bank,
    input  logic [7:0]        pg1_lo,
    input  logic              pg1_bank,
    output logic [ADDR_W-1:0] xlat_addr,
    output logic [3:0]        mem_sel,
    output logic [1:0]        bank_strobe
);
    localparam int PAGE_W = 8;
    localparam int LOW_W  = ADDR_W - PAGE_W;

    region_e           region;
    logic [1:0]        rom_sel;
    logic [PAGE_W-1:0] page_out;
    logic              share_hit;
    logic              col0;
    logic              both_cols;

    mmu_region_classify #(.ADDR_W(ADDR_W)) u_classify (
        .addr       (bus_addr),
        .cpu_owns   (cpu_owns),
        .compat     (compat),
        .overlay_en (!cpu_sel && !cfg_reg[6]),
        .region     (region)
    );

    mmu_rom_select u_rom (
        .region  (region),
        .rom_lo  (cfg_reg[1]),
        .rom_mid (cfg_reg[3:2]),
        .rom_hi  (cfg_reg[5:4]),
        .sel     (rom_sel)
    );

    mmu_page_map #(.PAGE_W(PAGE_W)) u_page (
        .region   (region),
        .page_in  (bus_addr[ADDR_W-1 -: PAGE_W]),
        .ram_sel  (&rom_sel),
        .pg0_lo   (pg0_lo),
        .pg1_lo   (pg1_lo),
        .page_out (page_out)
    );

    mmu_share_window #(.ADDR_W(ADDR_W)) u_share (
        .addr      (bus_addr),
        .size_code (share_size),
        .bottom_en (share_bottom),
        .top_en    (share_top),
        .hit       (share_hit)
    );

    always_comb begin
        both_cols = 1'b0;
        unique case (region)
            RG_VIDEO:  col0 = vid_bank;
            RG_MMUREG: begin
                col0      = 1'b1;
                both_cols = 1'b1;
            end
            RG_PAGE0:  col0 = pg0_bank;
            RG_PAGE1:  col0 = pg1_bank;
            default:   col0 = cfg_reg[6];
        endcase
        if (ram_rules_apply(region) && share_hit)
            col0 = 1'b0;
    end

    assign bank_strobe = both_cols ? 2'b11 : {~col0, col0};
    assign mem_sel     = {~compat, cfg_reg[0], rom_sel};
    assign xlat_addr   = {page_out, bus_addr[LOW_W-1:0]};

endmodule

// File: rtl/mmu_xlat_chk.sv
module mmu_xlat_chk (
    input logic [15:0] bus_addr,
    input logic        cpu_owns,
    input logic        compat,
    input logic        cpu_sel,
    input logic [6:0]  cfg_reg,
    input logic [1:0]  share_size,
    input logic        share_bottom,
    input logic        share_top,
    input logic        vid_bank,
    input logic [7:0]  pg0_lo,
    input logic        pg0_bank,
    input logic [7:0]  pg1_lo,
    input logic        pg1_bank,
    input logic [15:0] xlat_addr,
    input logic [3:0]  mem_sel,
    input logic [1:0]  bank_strobe
);
    always_comb begin
        if (!cpu_owns) begin
            // R2
            vid_page_chk: assert (xlat_addr[15:12] == 4'hF &&
                                  xlat_addr[11:8] == bus_addr[11:8] &&
                                  bank_strobe == {~vid_bank, vid_bank});
        end
        if (cpu_owns && compat) begin
            // R3
            compat_pass_chk: assert (xlat_addr == bus_addr && mem_sel[1:0] == 2'b11 &&
                                     bank_strobe == {~cfg_reg[6], cfg_reg[6]});
        end
        if (cpu_owns && !compat && bus_addr >= 16'hFF00 && bus_addr <= 16'hFF04) begin
            // R4
            regwin_cas_chk: assert (bank_strobe == 2'b11 && xlat_addr == bus_addr);
        end
        if (cpu_owns && !compat && !cpu_sel && !cfg_reg[6] && bus_addr < 16'h1000) begin
            // R5
            overlay_chk: assert (mem_sel[1:0] == 2'b00 && xlat_addr[15:12] == 4'hD);
        end
        // R9
        col_nonzero_chk: assert (bank_strobe != 2'b00);
    end

    // unused by the checks above but kept so the port list mirrors the top
    logic unused_ok;
    assign unused_ok = ^{share_size, share_bottom, share_top, pg0_lo, pg0_bank,
                         pg1_lo, pg1_bank, mem_sel[3:2]};

endmodule

bind mmu_xlat_top mmu_xlat_chk u_chk (.*);

// File: tb/mmu_xlat_top_test.sv
module mmu_xlat_top_test;

    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic [15:0] bus_addr;
    logic        cpu_owns, compat, cpu_sel;
    logic [6:0]  cfg_reg;
    logic [1:0]  share_size;
    logic        share_bottom, share_top, vid_bank;
    logic [7:0]  pg0_lo, pg1_lo;
    logic        pg0_bank, pg1_bank;
    logic [15:0] xlat_addr;
    logic [3:0]  mem_sel;
    logic [1:0]  bank_strobe;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    mmu_xlat_top uut (
        .bus_addr(bus_addr), .cpu_owns(cpu_owns), .compat(compat), .cpu_sel(cpu_sel),
        .cfg_reg(cfg_reg), .share_size(share_size), .share_bottom(share_bottom),
        .share_top(share_top), .vid_bank(vid_bank), .pg0_lo(pg0_lo), .pg0_bank(pg0_bank),
        .pg1_lo(pg1_lo), .pg1_bank(pg1_bank), .xlat_addr(xlat_addr), .mem_sel(mem_sel),
        .bank_strobe(bank_strobe)
    );

    task automatic compare(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s addr=%h got=%h expected=%h", tag, bus_addr, got, exp);
        end
    endtask

    // behavioural reference: page, ms01 = ms0 + 2*ms1, cas = cas0 + 2*cas1
    task automatic model(output int page, output int ms01, output int cas,
                         output string page_tag, output string ms_tag, output string cas_tag);
        int a, pg, ms0, ms1, c0, c1, span;
        bit ram_rules;
        a = int'(bus_addr);
        pg = a / 256;
        ms0 = 1; ms1 = 1; ram_rules = 0;
        page_tag = "R3"; ms_tag = "R1"; cas_tag = "R3";
        if (!cpu_owns) begin
            page = 240 + (pg % 16);
            c0 = vid_bank; c1 = 1 - c0;
            page_tag = "R2"; cas_tag = "R2";
        end else begin
            page = pg; c0 = cfg_reg[6]; c1 = 1 - c0;
            if (!compat) begin
                if (a >= 'hFF00 && a <= 'hFF04) begin
                    c0 = 1; c1 = 1; cas_tag = "R4"; page_tag = "R4";
                end else if (!cpu_sel && !cfg_reg[6] && a < 'h1000) begin
                    page = 'hD0 + (pg % 16); ms0 = 0; ms1 = 0;
                    page_tag = "R5"; ms_tag = "R5";
                end else begin
                    ram_rules = 1;
                    if (pg == 0) begin
                        page = pg0_lo; c0 = pg0_bank; c1 = 1 - c0;
                        page_tag = "R6"; cas_tag = "R6";
                    end else if (pg == 1) begin
                        page = pg1_lo; c0 = pg1_bank; c1 = 1 - c0;
                        page_tag = "R6"; cas_tag = "R6";
                    end else if (a >= 'h4000 && a < 'h8000) begin
                        ms0 = cfg_reg[1]; ms1 = cfg_reg[1]; ms_tag = "R7";
                    end else if (a >= 'h8000 && a < 'hC000) begin
                        ms0 = cfg_reg[2]; ms1 = cfg_reg[3]; ms_tag = "R7";
                    end else if (a >= 'hC000) begin
                        ms0 = cfg_reg[4]; ms1 = cfg_reg[5]; ms_tag = "R7";
                    end
                    if (ms0 == 1 && ms1 == 1) begin
                        if (pg == pg0_lo) begin page = 0; page_tag = "R8"; end
                        else if (pg == pg1_lo) begin page = 1; page_tag = "R8"; end
                    end
                end
                if (ram_rules) begin
                    span = (share_size == 0) ? 1024 : (4096 << (share_size - 1));
                    if ((share_bottom && a < span) || (share_top && a >= 65536 - span)) begin
                        c0 = 0; c1 = 1; cas_tag = "R9";
                    end
                end
            end
        end
        ms01 = ms0 + 2 * ms1;
        cas = c0 + 2 * c1;
    endtask

    task automatic check_now();
        int page, ms01, cas;
        string pt, mt, ct;
        model(page, ms01, cas, pt, mt, ct);
        compare(pt, int'(xlat_addr[15:8]), page);
        compare("R10", int'(xlat_addr[7:0]), int'(bus_addr[7:0]));
        compare(mt, int'(mem_sel[1:0]), ms01);
        compare("R1", int'(mem_sel[3:2]), int'(!compat) * 2 + int'(cfg_reg[0]));
        compare(ct, int'(bank_strobe), cas);
    endtask

    function automatic logic [15:0] pick_addr(input int sel);
        logic [15:0] edges [20] = '{16'h0000, 16'h00FF, 16'h0100, 16'h01FF, 16'h03FF, 16'h0400,
                                   16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000,
                                   16'hBFFF, 16'hC000, 16'hDFFF, 16'hE000, 16'hEFFF, 16'hF000,
                                   16'hFBFF, 16'hFC00};
        unique case (sel)
            0:       return edges[$urandom_range(0, 19)];
            1:       return 16'hFF00 + 16'($urandom_range(0, 6));
            2:       return {pg0_lo, 8'($urandom)};
            3:       return {pg1_lo, 8'($urandom)};
            4:       return {7'd0, 1'($urandom), 8'($urandom)};
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic drive_random();
        cpu_owns     = ($urandom_range(0, 3) != 0);
        compat       = ($urandom_range(0, 4) == 0);
        cpu_sel      = 1'($urandom);
        cfg_reg      = 7'($urandom);
        share_size   = 2'($urandom);
        share_bottom = 1'($urandom);
        share_top    = 1'($urandom);
        vid_bank     = 1'($urandom);
        pg0_lo       = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 1)) : 8'($urandom);
        pg1_lo       = 8'($urandom);
        pg0_bank     = 1'($urandom);
        pg1_bank     = 1'($urandom);
        bus_addr     = pick_addr($urandom_range(0, 6));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        bus_addr = '0; cpu_owns = 1'b1; compat = 1'b0; cpu_sel = 1'b0; cfg_reg = '0;
        share_size = '0; share_bottom = 1'b0; share_top = 1'b0; vid_bank = 1'b0;
        pg0_lo = 8'h00; pg0_bank = 1'b0; pg1_lo = 8'h01; pg1_bank = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // reset-state inputs: overlay active at address 0 (R5, R1)
        compare("R5", int'(xlat_addr), 16'hD000);
        compare("R1", int'(mem_sel), 4'b1000);
        rst_n = 1'b1;

        // directed: zero page relocated into bank 1 but bottom share forces bank 0 (R6, R9)
        @(negedge clk);
        cpu_sel = 1'b1; pg0_lo = 8'h37; pg0_bank = 1'b1; share_bottom = 1'b1; share_size = 2'd0;
        bus_addr = 16'h0042;
        #1;
        compare("R6", int'(xlat_addr), 16'h3742);
        compare("R9", int'(bank_strobe), 2'b10);
        check_now();

        // directed: swap-back of the target page, top share 16K (R8, R9)
        @(negedge clk);
        share_bottom = 1'b0; share_top = 1'b1; share_size = 2'd3; cfg_reg = 7'h7F;
        pg0_lo = 8'hE5; bus_addr = 16'hE512;
        #1;
        compare("R8", int'(xlat_addr), 16'h0012);
        compare("R9", int'(bank_strobe), 2'b10);
        check_now();

        // directed: register window both strobes high (R4)
        @(negedge clk);
        bus_addr = 16'hFF04;
        #1;
        compare("R4", int'(bank_strobe), 2'b11);
        check_now();

        // directed: video access (R2)
        @(negedge clk);
        cpu_owns = 1'b0; vid_bank = 1'b1; bus_addr = 16'h2A99;
        #1;
        compare("R2", int'(xlat_addr), 16'hFA99);
        check_now();

        // directed: compatibility mode passes everything (R3)
        @(negedge clk);
        cpu_owns = 1'b1; compat = 1'b1; bus_addr = 16'h0010;
        #1;
        compare("R3", int'(xlat_addr), 16'h0010);
        check_now();

        // directed: mid ROM window split select (R7)
        @(negedge clk);
        compat = 1'b0; share_top = 1'b0; cfg_reg = 7'b0000100; bus_addr = 16'h9000;
        #1;
        compare("R7", int'(mem_sel[1:0]), 2'b01);
        check_now();

        // sweep of every share size with both edges and both owners
        for (int sz = 0; sz < 4; sz++) begin
            for (int e = 0; e < 20; e++) begin
                @(negedge clk);
                drive_random();
                share_size = 2'(sz); share_bottom = 1'b1; share_top = 1'b1;
                bus_addr = pick_addr(0);
                #1;
                check_now();
            end
        end

        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            drive_random();
            #1;
            check_now();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule